// File: doc/BRIEF.md
# Extended control register write checker

This block guards the write path into a bank of 64-bit extended control registers, of which only index 0 is implemented. A request carries a 32-bit register index and two 32-bit data words. The high word becomes bits 63:32 of the new value and the low word becomes bits 31:0. Alongside the request the block sees the current execution state: privilege level, real-address mode, virtual-8086 mode, a lock-prefix flag, a flag saying the feature is supported, and a flag saying the operating system has enabled it.

Each request is judged in one cycle. The block either commits the value into register 0 or reports one fault. An invalid-opcode fault is reported when the feature is unavailable or misused. A general-protection fault, always with error code zero, is reported for privilege, index or value violations. Invalid-opcode conditions outrank general-protection conditions. The register's current value is always visible on a read port. A synthesis parameter sets which bits of register 0 are writable; all other bits are reserved.

Top module: `xcr_write_unit`

## Requirements
- R1: While reset is asserted and after it is released, xcr0_o reads 64'h1, and done_o, commit_o and fault_o are 0.
- R2: Each cycle with req_valid_i high yields exactly one cycle with done_o high on the following cycle, and done_o is low otherwise. In a done cycle exactly one of commit_o and fault_o is high. fault_type_o encodes 2'b00 none, 2'b01 invalid-opcode, 2'b10 general-protection.
- R3: If feat_sup_i is 0, os_en_i is 0 or lock_i is 1, the result is an invalid-opcode fault, whatever the other inputs are.
- R4: With no invalid-opcode condition, v86_mode_i high always gives a general-protection fault, even at privilege 0 or in real mode.
- R5: Outside real mode (real_mode_i low), a privilege level cpl_i other than 0 gives a general-protection fault. In real mode any cpl_i is accepted.
- R6: Any req_index_i other than 0, with all 32 bits compared, gives a general-protection fault.
- R7: A value that sets any bit outside parameter SUP_MASK (default 64'h7, bits 0 to 2) gives a general-protection fault. This includes bits in the high word.
- R8: A value with bit 0 clear gives a general-protection fault.
- R9: A value with bits 2:1 equal to 2'b10 gives a general-protection fault.
- R10: An accepted request loads {req_hi_i, req_lo_i} into register 0. The new value shows on xcr0_o in the same cycle as its done pulse. A faulting request leaves xcr0_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request strobe, one request per high cycle |
| req_index_i | input | 32 | Register index |
| req_hi_i | input | 32 | Data for bits 63:32 |
| req_lo_i | input | 32 | Data for bits 31:0 |
| cpl_i | input | 2 | Current privilege level |
| real_mode_i | input | 1 | Real-address mode active |
| v86_mode_i | input | 1 | Virtual-8086 mode active |
| lock_i | input | 1 | Lock prefix present on the request |
| feat_sup_i | input | 1 | Feature supported by the core |
| os_en_i | input | 1 | Feature enabled by the operating system |
| done_o | output | 1 | One-cycle result pulse |
| commit_o | output | 1 | Request was committed |
| fault_o | output | 1 | Request faulted |
| fault_type_o | output | 2 | Fault class: 00 none, 01 invalid-opcode, 10 general-protection |
| xcr0_o | output | 64 | Current value of register 0 |

## Verification
The bench aims at requests that break several rules at once. An example is a locked request from virtual-8086 mode to a bad index: a design that checked general-protection first would report the wrong class. Indices that differ from zero only in bit 31, and reserved bits set only in the high word, catch designs that compare a truncated index or check only the low word. Real mode at privilege 3, and virtual-8086 mode at privilege 0, separate a correct privilege rule from one that looks at only one of the two mode inputs. After every faulting request the bench reads the register back, so a design that writes before it finishes checking would show a changed value.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_UD   = 2'b01,
    FLT_GP   = 2'b10
  } flt_e;
endpackage

// File: rtl/xcr_mode_check.sv
module xcr_mode_check (
  input  logic [1:0] cpl_i,
  input  logic       real_mode_i,
  input  logic       v86_mode_i,
  input  logic       lock_i,
  input  logic       feat_sup_i,
  input  logic       os_en_i,
  output logic       ud_o,
  output logic       gp_o
);
  always_comb begin
    ud_o = !feat_sup_i || !os_en_i || lock_i;
    // v86 rejects regardless of real/cpl
    gp_o = v86_mode_i || (!real_mode_i && (cpl_i != 2'd0));
  end
endmodule

// File: rtl/xcr_value_check.sv
module xcr_value_check #(
  parameter int          IDX_W    = 32,
  parameter int          XLEN     = 64,
  parameter logic [63:0] SUP_MASK = 64'h7
) (
  input  logic [IDX_W-1:0] index_i,
  input  logic [XLEN-1:0]  data_i,
  output logic             gp_o
);
  logic [XLEN-1:0] rsvd_hit;

  for (genvar b = 0; b < XLEN; b++) begin : g_rsvd
    if (SUP_MASK[b]) begin : g_sup
      assign rsvd_hit[b] = 1'b0;
    end else begin : g_res
      assign rsvd_hit[b] = data_i[b];
    end
  end

  logic bad_idx, bad_rsvd, bad_base, bad_dep;
  always_comb begin
    bad_idx  = |index_i;
    bad_rsvd = |rsvd_hit;
    bad_base = !data_i[0];
    bad_dep  = data_i[2] && !data_i[1];
    gp_o     = bad_idx || bad_rsvd || bad_base || bad_dep;
  end
endmodule

// File: rtl/xcr_reg_bank.sv
module xcr_reg_bank #(
  parameter int             XLEN    = 64,
  parameter logic [XLEN-1:0] RST_VAL = 64'h1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] xcr0_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   xcr0_q <= RST_VAL;
    else if (we_i) xcr0_q <= wdata_i;
  end
  assign rdata_o = xcr0_q;
endmodule

// File: rtl/xcr_write_unit.sv
module xcr_write_unit #(
  parameter int          IDX_W    = 32,
  parameter int          HALF_W   = 32,
  parameter logic [63:0] SUP_MASK = 64'h7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [IDX_W-1:0]    req_index_i,
  input  logic [HALF_W-1:0]   req_hi_i,
  input  logic [HALF_W-1:0]   req_lo_i,
  input  logic [1:0]          cpl_i,
  input  logic                real_mode_i,
  input  logic                v86_mode_i,
  input  logic                lock_i,
  input  logic                feat_sup_i,
  input  logic                os_en_i,
  output logic                done_o,
  output logic                commit_o,
  output logic                fault_o,
  output logic [1:0]          fault_type_o,
  output logic [2*HALF_W-1:0] xcr0_o
);
  import xcr_pkg::*;
  localparam int XLEN = 2 * HALF_W;
  localparam logic [XLEN-1:0] RST_VAL = XLEN'(1);

  logic [XLEN-1:0] wdata;
  logic            ud, gp_mode, gp_val, we;
  flt_e            flt_sel, flt_q;
  logic            done_q;

  assign wdata = {req_hi_i, req_lo_i};

  xcr_mode_check u_mode (
    .cpl_i       (cpl_i),
    .real_mode_i (real_mode_i),
    .v86_mode_i  (v86_mode_i),
    .lock_i      (lock_i),
    .feat_sup_i  (feat_sup_i),
    .os_en_i     (os_en_i),
    .ud_o        (ud),
    .gp_o        (gp_mode)
  );

  xcr_value_check #(
    .IDX_W    (IDX_W),
    .XLEN     (XLEN),
    .SUP_MASK (SUP_MASK)
  ) u_val (
    .index_i (req_index_i),
    .data_i  (wdata),
    .gp_o    (gp_val)
  );

  always_comb begin
    if (ud)                    flt_sel = FLT_UD;
    else if (gp_mode || gp_val) flt_sel = FLT_GP;
    else                       flt_sel = FLT_NONE;
  end

  assign we = req_valid_i && (flt_sel == FLT_NONE);

  xcr_reg_bank #(
    .XLEN    (XLEN),
    .RST_VAL (RST_VAL)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (xcr0_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      flt_q  <= FLT_NONE;
    end else begin
      done_q <= req_valid_i;
      flt_q  <= req_valid_i ? flt_sel : FLT_NONE;
    end
  end

  assign done_o       = done_q;
  assign fault_type_o = flt_q;
  assign fault_o      = flt_q != FLT_NONE;
  assign commit_o     = done_q && (flt_q == FLT_NONE);
endmodule

// File: rtl/xcr_write_unit_chk.sv
module xcr_write_unit_chk #(
  parameter int          XLEN     = 64,
  parameter logic [63:0] SUP_MASK = 64'h7
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [31:0]     req_index_i,
  input logic [XLEN-1:0] wdata,
  input logic [1:0]      cpl_i,
  input logic            real_mode_i,
  input logic            v86_mode_i,
  input logic            lock_i,
  input logic            feat_sup_i,
  input logic            os_en_i,
  input logic            done_o,
  input logic            commit_o,
  input logic            fault_o,
  input logic [1:0]      fault_type_o,
  input logic [XLEN-1:0] xcr0_o
);
  a_r2_done_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  a_r2_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (commit_o != fault_o));
  a_r2_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!commit_o && !fault_o));
  a_r3_ud_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (!feat_sup_i || !os_en_i || lock_i)) |=> fault_type_o == 2'b01);
  a_r4_v86_gp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && feat_sup_i && os_en_i && !lock_i && v86_mode_i) |=> fault_type_o == 2'b10);
  a_r5_priv_gp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && feat_sup_i && os_en_i && !lock_i && !real_mode_i && cpl_i != 2'd0)
    |=> fault_type_o == 2'b10);
  a_r6_index_gp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && feat_sup_i && os_en_i && !lock_i && req_index_i != 32'd0)
    |=> fault_type_o == 2'b10);
  a_r7_rsvd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcr0_o & ~SUP_MASK[XLEN-1:0]) == '0);
  a_r8_bit0_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcr0_o[0]);
  a_r9_dep_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcr0_o[2] |-> xcr0_o[1]);
  a_r10_commit_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> xcr0_o == $past(wdata));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable(xcr0_o));
endmodule

bind xcr_write_unit xcr_write_unit_chk #(
  .XLEN     (XLEN),
  .SUP_MASK (SUP_MASK)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_index_i  (req_index_i),
  .wdata        (wdata),
  .cpl_i        (cpl_i),
  .real_mode_i  (real_mode_i),
  .v86_mode_i   (v86_mode_i),
  .lock_i       (lock_i),
  .feat_sup_i   (feat_sup_i),
  .os_en_i      (os_en_i),
  .done_o       (done_o),
  .commit_o     (commit_o),
  .fault_o      (fault_o),
  .fault_type_o (fault_type_o),
  .xcr0_o       (xcr0_o)
);

// File: tb/xcr_write_unit_tb.sv
module xcr_write_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_index_i = '0, req_hi_i = '0, req_lo_i = 32'h1;
  logic [1:0]  cpl_i = '0;
  logic        real_mode_i = 1'b0, v86_mode_i = 1'b0, lock_i = 1'b0;
  logic        feat_sup_i = 1'b1, os_en_i = 1'b1;
  logic        done_o, commit_o, fault_o;
  logic [1:0]  fault_type_o;
  logic [63:0] xcr0_o;

  localparam logic [63:0] MASK = 64'h7;

  int checks = 0, fails = 0;
  logic [63:0] model = 64'h1;

  always #4 clk_i = ~clk_i;

  xcr_write_unit u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string exp_tag(input logic [31:0] idx, input logic [63:0] d,
      input logic [1:0] cpl, input bit rm, input bit v86, input bit lk, input bit fs, input bit oe);
    if (!fs || !oe || lk)         return "R3";
    if (v86)                      return "R4";
    if (!rm && cpl != 2'd0)       return "R5";
    if (idx != 32'd0)             return "R6";
    if ((d & ~MASK) != 64'd0)     return "R7";
    if (!d[0])                    return "R8";
    if (d[2:1] == 2'b10)          return "R9";
    return "R10";
  endfunction

  function automatic logic [1:0] tag_type(input string t);
    if (t == "R3")  return 2'b01;
    if (t == "R10") return 2'b00;
    return 2'b10;
  endfunction

  task automatic do_req(input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] lo,
      input logic [1:0] cpl, input bit rm, input bit v86, input bit lk, input bit fs, input bit oe);
    string t;
    logic [1:0] et;
    t  = exp_tag(idx, {hi, lo}, cpl, rm, v86, lk, fs, oe);
    et = tag_type(t);
    req_valid_i = 1'b1; req_index_i = idx; req_hi_i = hi; req_lo_i = lo;
    cpl_i = cpl; real_mode_i = rm; v86_mode_i = v86; lock_i = lk;
    feat_sup_i = fs; os_en_i = oe;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (et == 2'b00) model = {hi, lo};
    chk(done_o === 1'b1, "R2 done pulse", 64'(done_o), 64'd1);
    chk(fault_type_o === et, t, 64'(fault_type_o), 64'(et));
    chk(commit_o === (et == 2'b00) && fault_o === (et != 2'b00), "R2 outcome",
        {62'd0, commit_o, fault_o}, {62'd0, et == 2'b00, et != 2'b00});
    chk(xcr0_o === model, "R10 register value", xcr0_o, model);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R2 no done when idle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (2) @(negedge clk_i);
    chk(xcr0_o === 64'h1, "R1 reset value", xcr0_o, 64'h1);
    chk(done_o === 1'b0 && fault_o === 1'b0 && commit_o === 1'b0, "R1 outputs idle",
        {61'd0, done_o, fault_o, commit_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(xcr0_o === 64'h1, "R1 value after release", xcr0_o, 64'h1);

    // directed corners
    do_req(32'd0, 32'd0, 32'h7, 2'd0, 0, 0, 0, 1, 1);          // R10 commit
    do_req(32'd0, 32'd0, 32'h6, 2'd0, 0, 0, 0, 1, 1);          // R8
    do_req(32'd0, 32'd0, 32'h5, 2'd0, 0, 0, 0, 1, 1);          // R9
    do_req(32'd0, 32'h1, 32'h3, 2'd0, 0, 0, 0, 1, 1);          // R7 high word
    do_req(32'd0, 32'd0, 32'hB, 2'd0, 0, 0, 0, 1, 1);          // R7 low word
    do_req(32'd1, 32'd0, 32'h3, 2'd0, 0, 0, 0, 1, 1);          // R6
    do_req(32'h8000_0000, 32'd0, 32'h3, 2'd0, 0, 0, 0, 1, 1);  // R6 top bit
    do_req(32'd0, 32'd0, 32'h3, 2'd3, 0, 0, 0, 1, 1);          // R5 cpl 3
    do_req(32'd0, 32'd0, 32'h3, 2'd3, 1, 0, 0, 1, 1);          // R5 real mode ok
    do_req(32'd0, 32'd0, 32'h1, 2'd0, 1, 1, 0, 1, 1);          // R4 v86
    do_req(32'd5, 32'd0, 32'h0, 2'd3, 0, 1, 1, 1, 1);          // R3 lock beats all
    do_req(32'd0, 32'd0, 32'h7, 2'd0, 0, 0, 0, 0, 1);          // R3 feature off
    do_req(32'd0, 32'd0, 32'h7, 2'd0, 0, 0, 0, 1, 0);          // R3 os off
    do_req(32'd0, 32'd0, 32'h1, 2'd0, 0, 0, 0, 1, 1);          // R10 back to 1

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] idx, hi, lo;
      idx = ($urandom_range(3) == 0) ? ($urandom_range(1) ? 32'h1 << $urandom_range(31) : $urandom) : 32'd0;
      hi  = ($urandom_range(7) == 0) ? (32'h1 << $urandom_range(31)) : 32'd0;
      lo  = ($urandom_range(5) == 0) ? $urandom : 32'($urandom_range(7));
      do_req(idx, hi, lo, 2'($urandom_range(5) == 0 ? $urandom_range(3) : 0),
             $urandom_range(3) == 0, $urandom_range(7) == 0, $urandom_range(9) == 0,
             $urandom_range(11) != 0, $urandom_range(11) != 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule